// File: doc/BRIEF.md
# Byte-Coded Operand-Stack Processor

This block runs a small program of byte-coded instructions taken from an external byte-wide program memory. It does not use operand addresses. Every arithmetic or transfer instruction works on an internal operand stack of 32-bit entries. Three variable registers hold results. The testbench reads these registers through read-only output ports. One instruction carries an inline operand byte, so instructions can be one or two bytes long.

A pulse on `start` sets the program counter to a base address given by a parameter, empties the stack and clears the error flag. The core then fetches, decodes and executes until it meets the return code or a fault. In both cases it stops and raises `halted`. On a fault it also raises `fault`. The program memory has a one-cycle read latency, as an FPGA block RAM does. The variable registers keep their values across runs and are cleared only by reset.

Top module: `bcm_core`

## Requirements
- R1: A `start` pulse while stopped or idle lowers `halted` and `fault`, empties the stack, and the first read then presents `pm_addr` equal to `PROG_BASE` with `pm_rd` high.
- R2: Code 0x10 uses the following program byte as its operand, sign-extends it from 8 to 32 bits and pushes it, so 0x80 pushes 0xFFFFFF80. Execution continues at the byte after the operand.
- R3: Code 0x03 pushes the value zero.
- R4: Codes 0x1B and 0x1C push the current value of variable 1 and variable 2 respectively.
- R5: Codes 0x3C, 0x3D and 0x3E pop the top entry into variable 1, 2 and 3 respectively. No other instruction changes a variable.
- R6: Code 0x60 replaces the two top entries with their sum modulo 2^32.
- R7: Code 0xB1 stops execution with `halted` high and `fault` low. While halted, no program read is issued.
- R8: The stack holds `STACK_DEPTH` entries (8 by default). Exactly that many pushes run without error. One more push raises `fault`, stops the core and leaves the variables unchanged.
- R9: A pop-to-variable on an empty stack, or an add with fewer than two entries, raises `fault` and stops the core without changing any variable.
- R10: Any code not listed in R2 to R7 raises `fault` and stops the core. No later instruction runs.
- R11: After reset, `halted`, `fault` and `pm_rd` are low and all three variables read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at PROG_BASE |
| pm_addr | output | PC_W | Program memory byte address |
| pm_rd | output | 1 | Program memory read enable |
| pm_data | input | 8 | Program byte, valid the cycle after the read |
| halted | output | 1 | Core stopped by return or fault |
| fault | output | 1 | Sticky error: stack bound or unknown code |
| var1 | output | DATA_W | Variable register 1 |
| var2 | output | DATA_W | Variable register 2 |
| var3 | output | DATA_W | Variable register 3 |

## Verification
The stack bounds are the hardest condition to reach, because the stack can only be seen through the variables. The bench fills the stack to exactly its depth with zero pushes and confirms that it finishes cleanly. It then adds a ninth push and confirms the fault. Underflow is reached by storing from an empty stack and by adding with a single entry. A store placed after each faulting instruction shows that the variables were left untouched. The variables persist between runs, so every expected value follows the history of earlier programs.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  localparam logic [7:0] OPC_PUSHB  = 8'h10;
  localparam logic [7:0] OPC_ZERO   = 8'h03;
  localparam logic [7:0] OPC_LDV1   = 8'h1B;
  localparam logic [7:0] OPC_LDV2   = 8'h1C;
  localparam logic [7:0] OPC_STV1   = 8'h3C;
  localparam logic [7:0] OPC_STV2   = 8'h3D;
  localparam logic [7:0] OPC_STV3   = 8'h3E;
  localparam logic [7:0] OPC_ADD    = 8'h60;
  localparam logic [7:0] OPC_RET    = 8'hB1;

  typedef enum logic [1:0] {
    STK_NONE,
    STK_PUSH,
    STK_POP,
    STK_ADD
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_ARG,
    ST_HALT
  } core_state_e;
endpackage

// File: rtl/bcm_stack.sv
module bcm_stack
  import bcm_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  stk_op_e      op,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty,
  output logic         has_two
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] idx_top;
  logic [CW-1:0] idx_sec;
  logic [W-1:0]  second;

  assign idx_top = count - CW'(1);
  assign idx_sec = count - CW'(2);
  assign top     = slots[idx_top[IW-1:0]];
  assign second  = slots[idx_sec[IW-1:0]];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign has_two = (count >= CW'(2));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else begin
      case (op)
        STK_PUSH: if (!full)   count <= count + CW'(1);
        STK_POP:  if (!empty)  count <= count - CW'(1);
        STK_ADD:  if (has_two) count <= count - CW'(1);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      if (op == STK_PUSH && !full)
        slots[count[IW-1:0]] <= din;
      else if (op == STK_ADD && has_two)
        slots[idx_sec[IW-1:0]] <= top + second;
    end
  end

  // R8: a push against a full stack leaves the depth as it was
  a_r8_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
    (op == STK_PUSH && full && !clear) |=> $stable(count));

  // R9: removing from an empty stack leaves the depth as it was
  a_r9_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
    (op == STK_POP && empty && !clear) |=> $stable(count));

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/bcm_vars.sv
module bcm_vars #(
  parameter int W = 32,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [1:0]     wsel,
  input  logic [W-1:0]   din,
  input  logic [1:0]     rsel,
  output logic [W-1:0]   rdata,
  output logic [N*W-1:0] all_vars
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_var
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && wsel == 2'(g + 1))
        regs[g] <= din;
    end
    assign all_vars[g*W +: W] = regs[g];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (rsel == 2'(i + 1)) rdata = regs[i];
  end

  // R5: variables change only on a store
  a_r5_vars_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(all_vars));
endmodule

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
#(
  parameter int              PC_W      = 16,
  parameter int              W         = 32,
  parameter logic [PC_W-1:0] PROG_BASE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [7:0]      pm_data,
  output logic [PC_W-1:0] pm_addr,
  output logic            pm_rd,
  input  logic            stk_full,
  input  logic            stk_empty,
  input  logic            stk_two,
  output stk_op_e         stk_op,
  output logic [W-1:0]    stk_din,
  output logic            stk_clear,
  input  logic [W-1:0]    var_rd,
  output logic [1:0]      var_rsel,
  output logic            var_we,
  output logic [1:0]      var_wsel,
  output logic            halted,
  output logic            fault
);
  core_state_e      state, nstate;
  logic [PC_W-1:0]  pc;
  logic             pc_inc;
  logic             set_fault;

  assign pm_addr = pc;
  assign halted  = (state == ST_HALT);
  assign pm_rd   = (state == ST_FETCH) || (state == ST_DECODE);

  always_comb begin
    nstate    = state;
    pc_inc    = 1'b0;
    set_fault = 1'b0;
    stk_op    = STK_NONE;
    stk_din   = '0;
    stk_clear = 1'b0;
    var_rsel  = 2'd0;
    var_we    = 1'b0;
    var_wsel  = 2'd0;
    case (state)
      ST_IDLE, ST_HALT: begin
        if (start) begin
          stk_clear = 1'b1;
          nstate    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        pc_inc = 1'b1;
        nstate = ST_DECODE;
      end
      ST_DECODE: begin
        nstate = ST_FETCH;
        case (pm_data)
          OPC_PUSHB: begin
            pc_inc = 1'b1;
            nstate = ST_ARG;
          end
          OPC_ZERO, OPC_LDV1, OPC_LDV2: begin
            var_rsel = (pm_data == OPC_LDV1) ? 2'd1 :
                       (pm_data == OPC_LDV2) ? 2'd2 : 2'd0;
            if (stk_full) begin
              set_fault = 1'b1;
            end else begin
              stk_op  = STK_PUSH;
              stk_din = (pm_data == OPC_ZERO) ? '0 : var_rd;
            end
          end
          OPC_STV1, OPC_STV2, OPC_STV3: begin
            if (stk_empty) begin
              set_fault = 1'b1;
            end else begin
              stk_op   = STK_POP;
              var_we   = 1'b1;
              var_wsel = (pm_data == OPC_STV1) ? 2'd1 :
                         (pm_data == OPC_STV2) ? 2'd2 : 2'd3;
            end
          end
          OPC_ADD: begin
            if (!stk_two) set_fault = 1'b1;
            else          stk_op    = STK_ADD;
          end
          OPC_RET: nstate = ST_HALT;
          default: set_fault = 1'b1;
        endcase
      end
      ST_ARG: begin
        nstate = ST_FETCH;
        if (stk_full) begin
          set_fault = 1'b1;
        end else begin
          stk_op  = STK_PUSH;
          stk_din = {{(W-8){pm_data[7]}}, pm_data};
        end
      end
      default: nstate = ST_IDLE;
    endcase
    if (set_fault) nstate = ST_HALT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= PROG_BASE;
      fault <= 1'b0;
    end else begin
      state <= nstate;
      if (stk_clear) begin
        pc    <= PROG_BASE;
        fault <= 1'b0;
      end else begin
        if (pc_inc)    pc    <= pc + PC_W'(1);
        if (set_fault) fault <= 1'b1;
      end
    end
  end

  // R2: each opcode fetch steps the byte address by one
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (pm_addr == $past(pm_addr) + PC_W'(1)));

  // R7: no program read while stopped
  a_r7_quiet_halt: assert property (@(posedge clk) disable iff (rst)
    halted |-> !pm_rd);

  // R10: a raised fault always comes with a stopped core
  a_r10_fault_stops: assert property (@(posedge clk) disable iff (rst)
    fault |-> halted);

  // R1: start from a stopped core goes straight to fetch at the base
  a_r1_start_base: assert property (@(posedge clk) disable iff (rst)
    (halted && start) |=> (pm_rd && pm_addr == PROG_BASE && !fault));
endmodule

// File: rtl/bcm_core.sv
module bcm_core
  import bcm_pkg::*;
#(
  parameter int              PC_W        = 16,
  parameter int              DATA_W      = 32,
  parameter int              STACK_DEPTH = 8,
  parameter logic [PC_W-1:0] PROG_BASE   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [PC_W-1:0]   pm_addr,
  output logic              pm_rd,
  input  logic [7:0]        pm_data,
  output logic              halted,
  output logic              fault,
  output logic [DATA_W-1:0] var1,
  output logic [DATA_W-1:0] var2,
  output logic [DATA_W-1:0] var3
);
  localparam int NVARS = 3;

  stk_op_e                   stk_op;
  logic [DATA_W-1:0]         stk_din, stk_top;
  logic                      stk_clear, stk_full, stk_empty, stk_two;
  logic [DATA_W-1:0]         var_rd;
  logic [1:0]                var_rsel, var_wsel;
  logic                      var_we;
  logic [NVARS*DATA_W-1:0]   all_vars;

  bcm_ctrl #(.PC_W(PC_W), .W(DATA_W), .PROG_BASE(PROG_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .pm_data(pm_data),
    .pm_addr(pm_addr), .pm_rd(pm_rd),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_two(stk_two),
    .stk_op(stk_op), .stk_din(stk_din), .stk_clear(stk_clear),
    .var_rd(var_rd), .var_rsel(var_rsel), .var_we(var_we), .var_wsel(var_wsel),
    .halted(halted), .fault(fault)
  );

  bcm_stack #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .clear(stk_clear), .op(stk_op), .din(stk_din),
    .top(stk_top), .full(stk_full), .empty(stk_empty), .has_two(stk_two)
  );

  bcm_vars #(.W(DATA_W), .N(NVARS)) u_vars (
    .clk(clk), .rst(rst), .we(var_we), .wsel(var_wsel), .din(stk_top),
    .rsel(var_rsel), .rdata(var_rd), .all_vars(all_vars)
  );

  assign var1 = all_vars[0*DATA_W +: DATA_W];
  assign var2 = all_vars[1*DATA_W +: DATA_W];
  assign var3 = all_vars[2*DATA_W +: DATA_W];
endmodule

// File: tb/sim_bcm_core.sv
module sim_bcm_core;
  localparam logic [15:0] BASE = 16'h0040;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [15:0] pm_addr;
  logic        pm_rd;
  logic [7:0]  pm_data;
  logic        halted, fault;
  logic [31:0] var1, var2, var3;

  always #4 clk = ~clk;

  bcm_core #(.PROG_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .start(start), .pm_addr(pm_addr), .pm_rd(pm_rd),
    .pm_data(pm_data), .halted(halted), .fault(fault),
    .var1(var1), .var2(var2), .var3(var3)
  );

  logic [7:0] mem [256];
  always_ff @(posedge clk) if (pm_rd) pm_data <= mem[pm_addr[7:0]];

  typedef struct {
    string       tag;
    logic [31:0] v1, v2, v3;
    logic        flt;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // monitor: compare results whenever the core newly stops
  logic prev_h = 1'b0;
  always @(negedge clk) begin
    if (!rst && halted && !prev_h) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=stop expected=none");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " var1"}, var1, e.v1);
        chk({e.tag, " var2"}, var2, e.v2);
        chk({e.tag, " var3"}, var3, e.v3);
        chk({e.tag, " fault"}, {31'd0, fault}, {31'd0, e.flt});
      end
    end
    prev_h <= halted;
  end

  task automatic run_prog(input string tag, input logic [7:0] code [$],
                          input logic [31:0] e1, input logic [31:0] e2,
                          input logic [31:0] e3, input logic ef);
    exp_t e;
    for (int i = 64; i < 256; i++) mem[i] = 8'h00;
    foreach (code[i]) mem[64 + i] = code[i];
    e.tag = tag; e.v1 = e1; e.v2 = e2; e.v3 = e3; e.flt = ef;
    sb_q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R1: first fetch at the base, flags low
    chk({tag, " R1 addr"}, {16'd0, pm_addr}, {16'd0, BASE});
    chk({tag, " R1 rd"}, {31'd0, pm_rd}, 32'd1);
    chk({tag, " R1 halted"}, {31'd0, halted}, 32'd0);
    for (int k = 0; k < 400 && !halted; k++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // R7: no read while stopped
    chk({tag, " R7 idle bus"}, {31'd0, pm_rd}, 32'd0);
  endtask

  initial begin
    logic [7:0] p [$];
    rst = 1'b1;
    start = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11 halted", {31'd0, halted}, 32'd0);
    chk("R11 fault", {31'd0, fault}, 32'd0);
    chk("R11 rd", {31'd0, pm_rd}, 32'd0);
    chk("R11 var1", var1, 32'd0);
    chk("R11 var2", var2, 32'd0);
    chk("R11 var3", var3, 32'd0);

    // R2 R3 R4 R5 R6 R7: reference program
    p = {8'h10, 8'h0F, 8'h3C, 8'h10, 8'h09, 8'h3D, 8'h03, 8'h3E,
         8'h1B, 8'h1C, 8'h60, 8'h3E, 8'hB1};
    run_prog("R6 main sum", p, 32'd15, 32'd9, 32'd24, 1'b0);

    // R2: sign extension of the inline byte
    p = {8'h10, 8'h80, 8'h3C, 8'h10, 8'h7F, 8'h3D, 8'hB1};
    run_prog("R2 sign ext", p, 32'hFFFFFF80, 32'h7F, 32'd24, 1'b0);

    // R6: wrap modulo 2^32
    p = {8'h10, 8'hFF, 8'h10, 8'hFF, 8'h60, 8'h3E, 8'hB1};
    run_prog("R6 wrap", p, 32'hFFFFFF80, 32'h7F, 32'hFFFFFFFE, 1'b0);

    // R4: loads of persisting variables
    p = {8'h1B, 8'h1C, 8'h60, 8'h3E, 8'hB1};
    run_prog("R4 load add", p, 32'hFFFFFF80, 32'h7F, 32'hFFFFFFFF, 1'b0);

    // R3 R8: exactly full stack is legal
    p = {8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h3C, 8'hB1};
    run_prog("R8 depth ok R3", p, 32'd0, 32'h7F, 32'hFFFFFFFF, 1'b0);

    // R8: one push too many
    p = {8'h10, 8'h05, 8'h10, 8'h05, 8'h10, 8'h05, 8'h10, 8'h05,
         8'h10, 8'h05, 8'h10, 8'h05, 8'h10, 8'h05, 8'h10, 8'h05,
         8'h10, 8'h05, 8'h3C, 8'hB1};
    run_prog("R8 overflow", p, 32'd0, 32'h7F, 32'hFFFFFFFF, 1'b1);

    // R9: store from empty stack
    p = {8'h3D, 8'hB1};
    run_prog("R9 empty store", p, 32'd0, 32'h7F, 32'hFFFFFFFF, 1'b1);

    // R9: add with a single entry
    p = {8'h10, 8'h07, 8'h60, 8'h3C, 8'hB1};
    run_prog("R9 short add", p, 32'd0, 32'h7F, 32'hFFFFFFFF, 1'b1);

    // R10: unknown code stops before the following store
    p = {8'h10, 8'h2A, 8'h57, 8'h3C, 8'hB1};
    run_prog("R10 bad code", p, 32'd0, 32'h7F, 32'hFFFFFFFF, 1'b1);

    // R1: fault cleared by a new start, R5 store to var1
    p = {8'h10, 8'h2A, 8'h3C, 8'hB1};
    run_prog("R1 restart R5", p, 32'h2A, 32'h7F, 32'hFFFFFFFF, 1'b0);

    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
    end
    finish_run();
  end
endmodule